// File: doc/BRIEF.md
# Multi-Mode Timer Waveform Generator

This block drives the outputs of a timer with four compare channels. One counter is shared by every channel. Each channel compares the counter against its own active compare value and moves its output level. A mode field picks one of seven waveform types: two frequency modes that toggle, one single-slope PWM mode, and four dual-slope PWM variants. The mode sets where the counter turns around, which register gives the top value, when buffered values become active and when the event strobe pulses.

Software writes the period and the compare values into buffer registers. Those values move into the active registers only at an update point, so a running waveform never sees a half-changed setting. For each channel a circular option, and one more for the period, writes the old active value back into the buffer at every update. Two values written once then alternate from period to period. Each channel drives a complementary output pair. A per-channel swap bit exchanges the two wires of that pair.

Top module: `tcwave_gen`

## Requirements
- R1: While reset is asserted and after it is released, every channel level is 0, so wave_o[3:0] = 0 and wave_o[7:4] = 1. evt_o and dir_o are 0, and all control fields, buffers and active values are 0.
- R2: Write port map. Address 0 is the control word: bits [2:0] mode, bit 3 circular period, bits [7:4] polarity per channel, bits [11:8] circular compare per channel, bits [15:12] swap per channel. Address 1 is the period buffer. Address 2+i is the compare buffer of channel i. If a control write carries mode code 3, the stored mode is kept and the other control fields still take the written values.
- R3: Modes 0, 1 and 2 count up from 0. At TOP the counter returns to 0, an update takes place, and evt_o is high for one cycle in the next cycle. TOP is the active compare value of channel 0 in mode 1 and the active period in every other mode. dir_o stays 0.
- R4: Modes 4 to 7 count up to TOP and then down to 0, so one period lasts 2*TOP cycles. dir_o is 1 while the counter counts down and 0 while it counts up.
- R5: In modes 0 and 1, a channel output toggles on each compare match and does not change at update.
- R6: In mode 2 with polarity 0, the channel level becomes 1 at update and 0 on compare match. Polarity 1 inverts both levels. When the match and the update fall in the same cycle, the update level wins.
- R7: In modes 4 to 7, a compare match drives the channel level to the inverse of dir_o when polarity is 0, and to dir_o when polarity is 1. Update does not change the level.
- R8: In modes 4 and 5, update and event both occur at zero. In mode 6 both occur at TOP and at zero. In mode 7, update occurs at zero and the event at TOP.
- R9: At every update, each active compare value and the active period take their buffer values.
- R10: With circular compare set for channel i, every update also writes the old active compare value of channel i into its buffer, so the two values alternate.
- R11: With circular period set, every update also writes the old active period into the period buffer.
- R12: wave_o[i] is channel level i and wave_o[i+4] is its inverse. When swap bit i is 1, the two wires of the pair are exchanged.
- R13: While en is 0, the counter, the direction and the channel levels hold, and evt_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| en | input | 1 | Count enable |
| wave_o | output | 8 | Waveform outputs, complementary pairs i and i+4 |
| evt_o | output | 1 | One-cycle overflow/update event strobe |
| dir_o | output | 1 | Counting direction, 1 = down |

## Verification
In one cycle, a compare match and an update can both try to set the same channel level. The bench provokes this in single-slope PWM by setting the compare value equal to the period, so the match happens on the TOP cycle. The level must then stay high for the whole period. The bench judges this by counting high cycles over four periods and comparing the count with the value the update-wins rule predicts. The circular tests also place the buffer copy-back and the active load in the same update cycle, and the bench judges them by the alternating duty and period lengths they produce.

// File: rtl/tcwave_pkg.sv
package tcwave_pkg;

  typedef enum logic [2:0] {
    WG_NFRQ   = 3'd0,
    WG_MFRQ   = 3'd1,
    WG_NPWM   = 3'd2,
    WG_RSVD   = 3'd3,
    WG_DSCRIT = 3'd4,
    WG_DSBOT  = 3'd5,
    WG_DSBOTH = 3'd6,
    WG_DSTOP  = 3'd7
  } wg_mode_e;

  function automatic logic mode_is_dual(wg_mode_e m);
    logic [2:0] mv;
    mv = m;
    return mv[2];
  endfunction

endpackage

// File: rtl/tcwave_regs.sv
module tcwave_regs
  import tcwave_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int AW  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     upd,
  output wg_mode_e                 mode_q,
  output logic                     circ_per_q,
  output logic [NCH-1:0]           pol_q,
  output logic [NCH-1:0]           circ_cmp_q,
  output logic [NCH-1:0]           swap_q,
  output logic [CW-1:0]            per_act_q,
  output logic [NCH-1:0][CW-1:0]   cc_act_q,
  output logic [NCH-1:0][CW-1:0]   cc_buf_q
);

  localparam int POL_LSB  = 4;
  localparam int CIRC_LSB = POL_LSB + NCH;
  localparam int SWAP_LSB = CIRC_LSB + NCH;
  localparam logic [AW-1:0] ADDR_CTRL = AW'(0);
  localparam logic [AW-1:0] ADDR_PER  = AW'(1);

  wg_mode_e                mode_n;
  logic                    circ_per_n;
  logic [NCH-1:0]          pol_n, circ_cmp_n, swap_n;
  logic [CW-1:0]           per_buf_q, per_buf_n, per_act_n;
  logic [NCH-1:0][CW-1:0]  cc_act_n, cc_buf_n;

  always_comb begin
    mode_n     = mode_q;
    circ_per_n = circ_per_q;
    pol_n      = pol_q;
    circ_cmp_n = circ_cmp_q;
    swap_n     = swap_q;
    per_buf_n  = per_buf_q;
    per_act_n  = per_act_q;
    cc_act_n   = cc_act_q;
    cc_buf_n   = cc_buf_q;

    // update point: buffers become active, optional copy-back
    if (upd) begin
      per_act_n = per_buf_q;
      if (circ_per_q) per_buf_n = per_act_q;
      for (int i = 0; i < NCH; i++) begin
        cc_act_n[i] = cc_buf_q[i];
        if (circ_cmp_q[i]) cc_buf_n[i] = cc_act_q[i];
      end
    end

    // a software write takes priority over copy-back
    if (wr_en) begin
      if (wr_addr == ADDR_CTRL) begin
        if (wr_data[2:0] != 3'(WG_RSVD)) mode_n = wg_mode_e'(wr_data[2:0]);
        circ_per_n = wr_data[3];
        pol_n      = wr_data[POL_LSB  +: NCH];
        circ_cmp_n = wr_data[CIRC_LSB +: NCH];
        swap_n     = wr_data[SWAP_LSB +: NCH];
      end
      if (wr_addr == ADDR_PER) per_buf_n = wr_data[CW-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == AW'(i + 2)) cc_buf_n[i] = wr_data[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= WG_NFRQ;
      circ_per_q <= 1'b0;
      pol_q      <= '0;
      circ_cmp_q <= '0;
      swap_q     <= '0;
      per_buf_q  <= '0;
      per_act_q  <= '0;
      cc_act_q   <= '0;
      cc_buf_q   <= '0;
    end else begin
      mode_q     <= mode_n;
      circ_per_q <= circ_per_n;
      pol_q      <= pol_n;
      circ_cmp_q <= circ_cmp_n;
      swap_q     <= swap_n;
      per_buf_q  <= per_buf_n;
      per_act_q  <= per_act_n;
      cc_act_q   <= cc_act_n;
      cc_buf_q   <= cc_buf_n;
    end
  end

endmodule

// File: rtl/tcwave_cnt.sv
module tcwave_cnt
  import tcwave_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  wg_mode_e      mode_i,
  input  logic [CW-1:0] top_i,
  output logic [CW-1:0] cnt_q,
  output logic          dir_q,
  output logic          upd_o,
  output logic          evt_q
);

  logic          dual, at_top, at_zero;
  logic [CW-1:0] cnt_n;
  logic          dir_n, upd_c, evt_c;

  always_comb begin
    dual    = mode_is_dual(mode_i);
    at_top  = (cnt_q == top_i) && (!dual || !dir_q);
    at_zero = (cnt_q == '0);
    cnt_n   = cnt_q;
    dir_n   = dir_q;
    upd_c   = 1'b0;
    evt_c   = 1'b0;

    if (!dual) begin
      upd_c = at_top;
      evt_c = at_top;
      cnt_n = at_top ? '0 : cnt_q + CW'(1);
    end else begin
      if (at_zero) begin
        cnt_n = (top_i == '0) ? '0 : CW'(1);
        dir_n = 1'b0;
      end else if (at_top) begin
        cnt_n = top_i - CW'(1);
        dir_n = 1'b1;
      end else begin
        cnt_n = dir_q ? cnt_q - CW'(1) : cnt_q + CW'(1);
      end
      case (mode_i)
        WG_DSBOTH: begin
          upd_c = at_top | at_zero;
          evt_c = at_top | at_zero;
        end
        WG_DSTOP: begin
          upd_c = at_zero;
          evt_c = at_top;
        end
        default: begin
          upd_c = at_zero;
          evt_c = at_zero;
        end
      endcase
    end

    if (!en_i) begin
      cnt_n = cnt_q;
      dir_n = dir_q;
      upd_c = 1'b0;
      evt_c = 1'b0;
    end
    if (!dual) dir_n = 1'b0;
  end

  assign upd_o = upd_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
      evt_q <= evt_c;
    end
  end

endmodule

// File: rtl/tcwave_chan.sv
module tcwave_chan
  import tcwave_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  wg_mode_e      mode_i,
  input  logic          pol_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dir_i,
  input  logic [CW-1:0] cc_i,
  input  logic          upd_i,
  output logic          out_q
);

  logic match, out_n;

  always_comb begin
    match = en_i && (cnt_i == cc_i);
    out_n = out_q;
    case (mode_i)
      WG_NFRQ, WG_MFRQ: begin
        if (match) out_n = ~out_q;
      end
      WG_NPWM: begin
        if (match) out_n = pol_i;
        if (upd_i) out_n = ~pol_i;
      end
      default: begin
        if (match) out_n = pol_i ? dir_i : ~dir_i;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_n;
  end

endmodule

// File: rtl/tcwave_omux.sv
module tcwave_omux #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0]   ch_i,
  input  logic [NCH-1:0]   swap_i,
  output logic [2*NCH-1:0] wave_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_pair
    logic lo_side, hi_side;
    assign lo_side       = ch_i[g];
    assign hi_side       = ~ch_i[g];
    assign wave_o[g]     = swap_i[g] ? hi_side : lo_side;
    assign wave_o[g+NCH] = swap_i[g] ? lo_side : hi_side;
  end

endmodule

// File: rtl/tcwave_gen.sv
module tcwave_gen
  import tcwave_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 4,
  localparam int CTRLW = 4 + 3 * NCH,
  localparam int DW    = (CW > CTRLW) ? CW : CTRLW,
  localparam int AW    = $clog2(NCH + 2),
  localparam int NOUT  = 2 * NCH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            en,
  output logic [NOUT-1:0] wave_o,
  output logic            evt_o,
  output logic            dir_o
);

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  wg_mode_e               mode_q;
  logic                   circ_per_q;
  logic [NCH-1:0]         pol_q, circ_cmp_q, swap_q;
  logic [CW-1:0]          per_act_q, top_val, cnt_q;
  logic [NCH-1:0][CW-1:0] cc_act_q, cc_buf_q;
  logic                   dir_q, upd, evt_q;
  logic [NCH-1:0]         ch_out;

  tcwave_regs #(.CW(CW), .NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_q),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .upd        (upd),
    .mode_q     (mode_q),
    .circ_per_q (circ_per_q),
    .pol_q      (pol_q),
    .circ_cmp_q (circ_cmp_q),
    .swap_q     (swap_q),
    .per_act_q  (per_act_q),
    .cc_act_q   (cc_act_q),
    .cc_buf_q   (cc_buf_q)
  );

  assign top_val = (mode_q == WG_MFRQ) ? cc_act_q[0] : per_act_q;

  tcwave_cnt #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_q),
    .en_i   (en),
    .mode_i (mode_q),
    .top_i  (top_val),
    .cnt_q  (cnt_q),
    .dir_q  (dir_q),
    .upd_o  (upd),
    .evt_q  (evt_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tcwave_chan #(.CW(CW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_q),
      .en_i   (en),
      .mode_i (mode_q),
      .pol_i  (pol_q[g]),
      .cnt_i  (cnt_q),
      .dir_i  (dir_q),
      .cc_i   (cc_act_q[g]),
      .upd_i  (upd),
      .out_q  (ch_out[g])
    );
  end

  tcwave_omux #(.NCH(NCH)) u_omux (
    .ch_i   (ch_out),
    .swap_i (swap_q),
    .wave_o (wave_o)
  );

  assign evt_o = evt_q;
  assign dir_o = dir_q;

endmodule

// File: rtl/tcwave_gen_chk.sv
module tcwave_gen_chk #(
  parameter int CW  = 16,
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [2*NCH-1:0]  wave_o,
  input logic              evt_o,
  input logic              dir_o,
  input logic [2:0]        mode,
  input logic [NCH-1:0]    pol,
  input logic [NCH-1:0]    circ_cmp,
  input logic              upd,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     top,
  input logic [NCH-1:0]    ch_out,
  input logic [CW-1:0]     cc_act0,
  input logic [CW-1:0]     cc_buf0
);

  // R3
  single_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[2]) |=> !dir_o);

  // R4
  dual_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dir_o) && mode[2] && $past(mode[2])) |-> ($past(cnt) == $past(top)));

  // R6
  npwm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && upd && !pol[0]) |=> ch_out[0]);

  // R8
  dstop_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7 && upd) |-> (cnt == '0));

  // R10
  circ_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && circ_cmp[0] && !(wr_en && wr_addr == AW'(2)))
      |=> (cc_buf0 == $past(cc_act0) && cc_act0 == $past(cc_buf0)));

  // R12
  pair_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wave_o[NCH-1:0] == ~wave_o[2*NCH-1:NCH]);

  // R13
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> ($stable(wave_o) && !evt_o && $stable(dir_o)));

endmodule

bind tcwave_gen tcwave_gen_chk #(.CW(CW), .NCH(NCH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .en       (en),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wave_o   (wave_o),
  .evt_o    (evt_o),
  .dir_o    (dir_o),
  .mode     (mode_q),
  .pol      (pol_q),
  .circ_cmp (circ_cmp_q),
  .upd      (upd),
  .cnt      (cnt_q),
  .top      (top_val),
  .ch_out   (ch_out),
  .cc_act0  (cc_act_q[0]),
  .cc_buf0  (cc_buf_q[0])
);

// File: tb/test_tcwave_gen.sv
module test_tcwave_gen;

  logic        clk, rst_n, wr_en, en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [7:0]  wave_o;
  logic        evt_o, dir_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_hi0, m_hi4, m_hi1, m_ev, m_dn, m_pair;

  tcwave_gen i_tcwave_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en(en), .wave_o(wave_o), .evt_o(evt_o), .dir_o(dir_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [2:0]  mode;
    logic        pol;
    logic [15:0] per;
    logic [15:0] cc;
    logic [15:0] len;
    logic [15:0] hi;
    logic [15:0] ev;
  } vec_t;

  localparam int NV = 9;
  // expected high cycles of wave_o[0] and events over four periods
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 16'd9,  16'd3, 16'd10, 16'd20, 16'd4},
    '{3'd1, 1'b0, 16'd20, 16'd5, 16'd6,  16'd12, 16'd4},
    '{3'd2, 1'b0, 16'd9,  16'd3, 16'd10, 16'd16, 16'd4},
    '{3'd2, 1'b1, 16'd9,  16'd3, 16'd10, 16'd24, 16'd4},
    '{3'd2, 1'b0, 16'd7,  16'd7, 16'd8,  16'd32, 16'd4},
    '{3'd4, 1'b0, 16'd8,  16'd3, 16'd16, 16'd40, 16'd4},
    '{3'd5, 1'b1, 16'd8,  16'd3, 16'd16, 16'd24, 16'd4},
    '{3'd6, 1'b0, 16'd6,  16'd2, 16'd12, 16'd32, 16'd8},
    '{3'd7, 1'b1, 16'd6,  16'd2, 16'd12, 16'd16, 16'd4}
  };

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    en = 1'b0; wr_en = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] ctrl, input logic [15:0] per,
                       input logic [15:0] cc0, input logic [15:0] ccn);
    do_reset();
    wr(3'd0, ctrl);
    wr(3'd1, per);
    wr(3'd2, cc0);
    for (int i = 3; i < 6; i++) wr(3'(i), ccn);
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic measure(input int n);
    m_hi0 = 0; m_hi4 = 0; m_hi1 = 0; m_ev = 0; m_dn = 0; m_pair = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      m_hi0  += int'(wave_o[0]);
      m_hi4  += int'(wave_o[4]);
      m_hi1  += int'(wave_o[1]);
      m_ev   += int'(evt_o);
      m_dn   += int'(dir_o);
      m_pair += int'(wave_o[0] == wave_o[4]);
    end
  endtask

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0, 3'd1: return "R5 R3 R9";
      3'd2:       return "R6 R3 R9";
      default:    return "R7 R8 R4";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;

    // R1 reset state
    do_reset();
    chk("R1 wave_o", int'(wave_o), 8'hF0);
    chk("R1 evt_o", int'(evt_o), 0);
    chk("R1 dir_o", int'(dir_o), 0);

    // table of modes
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int   L;
      t = VECS[v];
      L = int'(t.len);
      setup({8'h00, {4{t.pol}}, 1'b0, t.mode}, t.per, t.cc, t.cc);
      repeat (3 * L) @(negedge clk);
      measure(4 * L);
      chk(tag_of(t.mode), m_hi0, int'(t.hi));
      chk({tag_of(t.mode), " event"}, m_ev, int'(t.ev));
      chk(t.mode[2] ? "R4 down" : "R3 down", m_dn, t.mode[2] ? 2 * L : 0);
      chk("R12 pair", m_pair, 0);
    end

    // R2 reserved mode kept, polarity still written
    setup(16'h0002, 16'd9, 16'd3, 16'd3);
    repeat (30) @(negedge clk);
    wr(3'd0, 16'h00F3);
    repeat (30) @(negedge clk);
    measure(40);
    chk("R2 reserved mode duty", m_hi0, 24);
    chk("R2 reserved mode event", m_ev, 4);

    // R12 swap of pair 0 only
    setup(16'h1002, 16'd9, 16'd3, 16'd3);
    repeat (30) @(negedge clk);
    measure(40);
    chk("R12 swapped low wire", m_hi0, 24);
    chk("R12 swapped high wire", m_hi4, 16);
    chk("R12 unswapped pair1", m_hi1, 16);

    // R10 circular compare on channel 0
    setup(16'h0102, 16'd9, 16'd2, 16'd2);
    repeat (30) @(negedge clk);
    measure(40);
    chk("R10 circular duty", m_hi0, 8);
    chk("R9 plain channel duty", m_hi1, 12);

    // R11 circular period
    setup(16'h000A, 16'd9, 16'd20, 16'd20);
    repeat (33) @(negedge clk);
    measure(44);
    chk("R11 circular period events", m_ev, 8);
    chk("R11 level held high", m_hi0, 44);

    // R13 enable low freezes
    setup(16'h0004, 16'd8, 16'd3, 16'd3);
    repeat (37) @(negedge clk);
    en = 1'b0;
    measure(20);
    chk("R13 no event", m_ev, 0);
    chk("R13 level held", (m_hi0 == 0 || m_hi0 == 20) ? 1 : 0, 1);
    chk("R13 dir held", (m_dn == 0 || m_dn == 20) ? 1 : 0, 1);
    @(negedge clk);
    en = 1'b1;
    repeat (48) @(negedge clk);
    measure(64);
    chk("R13 resumed duty", m_hi0, 40);

    summary();
    $finish;
  end

endmodule